// File: doc/BRIEF.md
# DDR3 Clock-Enable Power-State Tracker

This block watches the control pins of a DDR3 memory device from the controller side and keeps a model of the device's power mode. On every rising clock edge it samples the clock-enable line together with the decoded command. It compares the clock-enable value at that edge with the value it registered at the edge before. From these and three side inputs it works out the next power state. The side inputs are: a bank is open, a read burst is running, a write burst is running.

The state machine has six states. ST_IDLE covers all banks closed with the clock enable high. ST_ACTIVE covers at least one bank open with the clock enable high. ST_APD is active power-down and ST_PPD is precharge power-down. ST_SREF is self refresh. ST_SRX is the timed window after self-refresh exit.

The named transitions are:
- pd_entry: the clock enable falls with NOP or DESELECT. It goes to ST_APD or ST_PPD.
- pd_exit: the clock enable rises out of ST_APD or ST_PPD. It goes to ST_ACTIVE or ST_IDLE.
- sr_entry: the clock enable falls with REFRESH. It goes to ST_SREF.
- sr_exit: the clock enable rises in ST_SREF. It goes to ST_SRX.
- srx_done: the read lock-out count expires. It goes from ST_SRX to ST_IDLE or ST_ACTIVE.
- hold_low: the clock enable stays low in a low-power state.
- track: the clock enable stays high. ST_IDLE and ST_ACTIVE then follow the bank-open input.

Five sticky violation flags report rule breaks. One down-counter times the clock-enable hold window, the no-command window after exit and the read lock-out window. The parameters must satisfy 1 <= TCKEMIN <= TXS <= TXSDLL and TXSDLL >= 2.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset the state output is ST_IDLE (code 0), all five flags are 0, `ref_credit` is 0, and the clock enable is taken as high at the previous edge.
- R2: Commands decode from {cs_n,ras_n,cas_n,we_n}. DESELECT is cs_n=1. NOP is 0111. REFRESH is 0001. READ is 0101. Every other pattern is "other". A REFRESH at an edge where the clock enable is high at both edges, in ST_IDLE, ST_ACTIVE or ST_SRX, makes `ref_credit` high for the one following cycle. A REFRESH with the clock enable low at both edges gives no credit.
- R3: The state codes are ST_IDLE=0, ST_ACTIVE=1, ST_APD=2, ST_PPD=3, ST_SREF=4 and ST_SRX=5. With the clock enable high at both edges, outside ST_SRX, the state becomes ST_ACTIVE if `bank_open` is 1 and ST_IDLE otherwise.
- R4: When the clock enable falls (high before, low now) with any command except REFRESH, the state becomes ST_APD if `bank_open` is 1 and ST_PPD otherwise. With the clock enable low at both edges, ST_APD and ST_PPD hold whatever the command.
- R5: When the clock enable rises in ST_APD or ST_PPD, the state becomes ST_ACTIVE if `bank_open` is 1 and ST_IDLE otherwise.
- R6: When the clock enable falls with REFRESH, the state becomes ST_SREF. `err_sref` is set if `bank_open`, `rd_busy` or `wr_busy` is 1, or if the state was ST_SRX.
- R7: ST_SREF holds while the clock enable stays low. When the clock enable rises in ST_SREF, the state becomes ST_SRX.
- R8: `err_cmd` is set when a command other than NOP or DESELECT comes with power-down entry, power-down exit or self-refresh exit.
- R9: `err_hold` is set when the clock enable changes at an edge fewer than TCKEMIN edges after its previous change.
- R10: In ST_SRX, take edge k as the k-th edge after the self-refresh exit edge. Any command other than NOP or DESELECT at an edge with k < TXS sets `err_xs`.
- R11: In ST_SRX, a READ at an edge with k < TXSDLL sets `err_rd`. At edge k = TXSDLL, with the clock enable high, the state leaves ST_SRX by the rule of R3.
- R12: The flags are sticky. A high `err_clr` at an edge clears them, but a violation detected at that same edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Sampled clock-enable line |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_open | input | 1 | At least one bank is open |
| rd_busy | input | 1 | A read burst is in progress |
| wr_busy | input | 1 | A write burst is in progress |
| err_clr | input | 1 | Clears the sticky flags |
| state_o | output | 3 | Current power state code (R3) |
| ref_credit | output | 1 | One-cycle pulse for a credited refresh |
| err_hold | output | 1 | Clock-enable hold violation |
| err_cmd | output | 1 | Illegal command on a power transition |
| err_sref | output | 1 | Illegal self-refresh entry |
| err_xs | output | 1 | Non-NOP command inside the post-exit window |
| err_rd | output | 1 | Read before the lock-out count expired |

## Verification
The bench walks the clock-enable change edge by edge across each window boundary.
- A hold violation is placed one edge too early. An off-by-one counter load would miss it or would flag a legal change.
- A READ is placed at the first edge after the no-command window. A design that merges the two windows would flag `err_xs` there or would miss `err_rd`.
- The bench checks that the state stays in ST_SRX until exactly edge TXSDLL.
- A REFRESH during power-down must give no credit. One with an open bank, a running read or a running write must set `err_sref`.
- Clear and set at the same edge must leave the flag set. A design that gives clear priority would lose the new violation.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_APD    = 3'd2,
        ST_PPD    = 3'd3,
        ST_SREF   = 3'd4,
        ST_SRX    = 3'd5
    } pwr_state_t;

    typedef enum logic [2:0] {
        CMD_DES   = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_REF   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_OTHER = 3'd4
    } cmd_t;

    localparam int NUM_FLAGS = 5;
    localparam int FL_HOLD   = 4;
    localparam int FL_CMD    = 3;
    localparam int FL_SREF   = 2;
    localparam int FL_XS     = 1;
    localparam int FL_RD     = 0;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
    import cke_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd,
    output logic quiet
);

    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DES;
        end else begin
            unique case (strobes)
                3'b111:  cmd = CMD_NOP;
                3'b001:  cmd = CMD_REF;
                3'b101:  cmd = CMD_READ;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

    assign quiet = (cmd == CMD_DES) || (cmd == CMD_NOP);

endmodule

// File: rtl/cke_window_timer.sv
module cke_window_timer #(
    parameter int TCKEMIN = 3,
    parameter int TXS     = 6,
    parameter int TXSDLL  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_hold,
    input  logic load_exit,
    output logic hold_ok,
    output logic xs_busy,
    output logic dll_busy
);

    localparam int CW = $clog2(TXSDLL + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(TCKEMIN - 1);
    localparam logic [CW-1:0] EXIT_LD = CW'(TXSDLL - 1);
    localparam logic [CW-1:0] XS_LIM  = CW'(TXSDLL - TXS);
    localparam logic [CW-1:0] HX_LIM  = CW'(TXSDLL - TCKEMIN);

    logic [CW-1:0] cnt;
    logic          exit_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            exit_mode <= 1'b0;
        end else if (load_exit) begin
            cnt       <= EXIT_LD;
            exit_mode <= 1'b1;
        end else if (load_hold) begin
            cnt       <= HOLD_LD;
            exit_mode <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign hold_ok  = exit_mode ? (cnt <= HX_LIM) : (cnt == '0);
    assign xs_busy  = exit_mode && (cnt > XS_LIM);
    assign dll_busy = exit_mode && (cnt != '0);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= EXIT_LD);

    // R11
    exit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_exit |=> dll_busy);

endmodule

// File: rtl/cke_err_flags.sv
module cke_err_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= set[i] | (q[i] & ~clr);
            end
        end

        // R12
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q[i]) |-> $past(clr));
    end

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
    import cke_trk_pkg::*;
#(
    parameter int TCKEMIN = 3,
    parameter int TXS     = 6,
    parameter int TXSDLL  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       bank_open,
    input  logic       rd_busy,
    input  logic       wr_busy,
    input  logic       err_clr,
    output logic [2:0] state_o,
    output logic       ref_credit,
    output logic       err_hold,
    output logic       err_cmd,
    output logic       err_sref,
    output logic       err_xs,
    output logic       err_rd
);

    pwr_state_t state, nxt;
    logic       cke_q;
    cmd_t       cmd;
    logic       quiet;
    logic       chg;
    logic       load_hold, load_exit;
    logic       hold_ok, xs_busy, dll_busy;
    logic       ev_hold, ev_cmd, ev_sref, ev_xs, ev_rd;
    logic       credit_nxt;
    logic [NUM_FLAGS-1:0] ev_vec, flag_q;

    cke_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd),
        .quiet (quiet)
    );

    assign chg       = (cke != cke_q);
    assign load_exit = (state == ST_SREF) && cke;
    assign load_hold = chg && !load_exit;

    cke_window_timer #(
        .TCKEMIN (TCKEMIN),
        .TXS     (TXS),
        .TXSDLL  (TXSDLL)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hold (load_hold),
        .load_exit (load_exit),
        .hold_ok   (hold_ok),
        .xs_busy   (xs_busy),
        .dll_busy  (dll_busy)
    );

    // Next-state and event decode
    always_comb begin
        nxt     = state;
        ev_cmd  = 1'b0;
        ev_sref = 1'b0;
        ev_xs   = (state == ST_SRX) && xs_busy && !quiet;
        ev_rd   = (state == ST_SRX) && dll_busy && (cmd == CMD_READ);
        ev_hold = chg && !hold_ok;
        unique case (state)
            ST_IDLE, ST_ACTIVE, ST_SRX: begin
                if (!cke) begin
                    if (cmd == CMD_REF) begin
                        nxt     = ST_SREF;
                        ev_sref = bank_open || rd_busy || wr_busy ||
                                  (state == ST_SRX);
                    end else begin
                        nxt    = bank_open ? ST_APD : ST_PPD;
                        ev_cmd = !quiet;
                    end
                end else if ((state == ST_SRX) && dll_busy) begin
                    nxt = ST_SRX;
                end else begin
                    nxt = bank_open ? ST_ACTIVE : ST_IDLE;
                end
            end
            ST_APD, ST_PPD: begin
                if (cke) begin
                    nxt    = bank_open ? ST_ACTIVE : ST_IDLE;
                    ev_cmd = !quiet;
                end
            end
            ST_SREF: begin
                if (cke) begin
                    nxt    = ST_SRX;
                    ev_cmd = !quiet;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign credit_nxt = cke && cke_q && (cmd == CMD_REF) &&
                        ((state == ST_IDLE) || (state == ST_ACTIVE) ||
                         (state == ST_SRX));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cke_q <= 1'b1;
        end else begin
            state <= nxt;
            cke_q <= cke;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_credit <= 1'b0;
        end else begin
            ref_credit <= credit_nxt;
        end
    end

    always_comb begin
        ev_vec          = '0;
        ev_vec[FL_HOLD] = ev_hold;
        ev_vec[FL_CMD]  = ev_cmd;
        ev_vec[FL_SREF] = ev_sref;
        ev_vec[FL_XS]   = ev_xs;
        ev_vec[FL_RD]   = ev_rd;
    end

    cke_err_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .set   (ev_vec),
        .q     (flag_q)
    );

    assign state_o  = state;
    assign err_hold = flag_q[FL_HOLD];
    assign err_cmd  = flag_q[FL_CMD];
    assign err_sref = flag_q[FL_SREF];
    assign err_xs   = flag_q[FL_XS];
    assign err_rd   = flag_q[FL_RD];

    // R3
    state_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_APD) || (state == ST_PPD) || (state == ST_SREF)) == !cke_q);

    // R7
    sref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SREF) && cke) |=> (state == ST_SRX));

    // R9
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_hold) |-> $past(cke != cke_q));

    // R2
    credit_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_credit |-> ($past(cke) && $past(cke_q)));

endmodule

// File: tb/cke_power_tracker_bench.sv
`timescale 1ns/1ps
module cke_power_tracker_bench;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_ACT = 4'b0011;

    // {cke, cmd[3:0], bank_open, rd_busy, wr_busy, clr, state[2:0], flags[4:0], credit, req[3:0]}
    // flags = {hold, cmd, sref, xs, rd}
    localparam int NV = 38;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd3},  // R3 idle
        {1'b1, C_NOP, 4'b1000, 3'd1, 5'b00000, 1'b0, 4'd3},  // R3 active
        {1'b0, C_NOP, 4'b1000, 3'd2, 5'b00000, 1'b0, 4'd4},  // R4 APD entry
        {1'b0, C_ACT, 4'b1000, 3'd2, 5'b00000, 1'b0, 4'd4},  // R4 low/low any cmd
        {1'b0, C_DES, 4'b1000, 3'd2, 5'b00000, 1'b0, 4'd4},
        {1'b1, C_NOP, 4'b1000, 3'd1, 5'b00000, 1'b0, 4'd5},  // R5 exit at k=3
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd3},
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd3},
        {1'b0, C_NOP, 4'b0000, 3'd3, 5'b00000, 1'b0, 4'd4},  // R4 PPD entry
        {1'b0, C_REF, 4'b0000, 3'd3, 5'b00000, 1'b0, 4'd2},  // R2 no credit in PD
        {1'b0, C_NOP, 4'b0000, 3'd3, 5'b00000, 1'b0, 4'd4},
        {1'b1, C_ACT, 4'b0000, 3'd0, 5'b01000, 1'b0, 4'd8},  // R8 illegal exit cmd
        {1'b1, C_NOP, 4'b0001, 3'd0, 5'b00000, 1'b0, 4'd12}, // R12 clear
        {1'b1, C_REF, 4'b0000, 3'd0, 5'b00000, 1'b1, 4'd2},  // R2 credit
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd2},
        {1'b0, C_REF, 4'b0000, 3'd4, 5'b00000, 1'b0, 4'd6},  // R6 legal SR entry
        {1'b0, C_NOP, 4'b0000, 3'd4, 5'b00000, 1'b0, 4'd7},
        {1'b0, C_DES, 4'b0000, 3'd4, 5'b00000, 1'b0, 4'd7},
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd7},  // R7 SR exit
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd10},
        {1'b1, C_ACT, 4'b0000, 3'd5, 5'b00010, 1'b0, 4'd10}, // R10 k=2
        {1'b1, C_NOP, 4'b0001, 3'd5, 5'b00000, 1'b0, 4'd12},
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd10},
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd10},
        {1'b1, C_RD,  4'b0000, 3'd5, 5'b00001, 1'b0, 4'd11}, // R11 k=6: rd only
        {1'b1, C_NOP, 4'b0001, 3'd5, 5'b00000, 1'b0, 4'd12},
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd11},
        {1'b1, C_NOP, 4'b0000, 3'd5, 5'b00000, 1'b0, 4'd11}, // k=9 still SRX
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd11}, // R11 k=10 leaves
        {1'b1, C_RD,  4'b0000, 3'd0, 5'b00000, 1'b0, 4'd11},
        {1'b0, C_NOP, 4'b0000, 3'd3, 5'b00000, 1'b0, 4'd4},
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b10000, 1'b0, 4'd9},  // R9 change at k=1
        {1'b1, C_NOP, 4'b0001, 3'd0, 5'b00000, 1'b0, 4'd12},
        {1'b1, C_NOP, 4'b0000, 3'd0, 5'b00000, 1'b0, 4'd9},
        {1'b0, C_REF, 4'b1000, 3'd4, 5'b00100, 1'b0, 4'd6},  // R6 bank open
        {1'b0, C_NOP, 4'b1000, 3'd4, 5'b00100, 1'b0, 4'd7},
        {1'b0, C_NOP, 4'b0000, 3'd4, 5'b00100, 1'b0, 4'd7},
        {1'b1, C_REF, 4'b0000, 3'd5, 5'b01100, 1'b0, 4'd8}   // R8 illegal SR exit
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic bank_open = 1'b0, rd_busy = 1'b0, wr_busy = 1'b0, err_clr = 1'b0;
    logic [2:0] state_o;
    logic ref_credit, err_hold, err_cmd, err_sref, err_xs, err_rd;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cke_power_tracker u_cke_power_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_open(bank_open), .rd_busy(rd_busy),
        .wr_busy(wr_busy), .err_clr(err_clr), .state_o(state_o),
        .ref_credit(ref_credit), .err_hold(err_hold), .err_cmd(err_cmd),
        .err_sref(err_sref), .err_xs(err_xs), .err_rd(err_rd)
    );

    function automatic logic [4:0] flags();
        return {err_hold, err_cmd, err_sref, err_xs, err_rd};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic [3:0] cm, input logic bo,
                        input logic rd, input logic wr, input logic cl);
        @(negedge clk);
        cke = c;
        {cs_n, ras_n, cas_n, we_n} = cm;
        bank_open = bo; rd_busy = rd; wr_busy = wr; err_clr = cl;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = C_NOP;
        bank_open = 1'b0; rd_busy = 1'b0; wr_busy = 1'b0; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check("R1", {4'b0, state_o, flags(), ref_credit} >> 0,
              {4'b0, 3'd0, 5'b00000, 1'b0});

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            string tag;
            v = VEC[i];
            step(v[21], v[20:17], v[16], v[15], v[14], v[13]);
            tag = $sformatf("R%0d row %0d", v[3:0], i);
            check(tag, {1'b0, state_o, flags(), ref_credit},
                  {1'b0, v[12:10], v[9:5], v[4]});
        end

        // R1 reset mid-run clears flags and state
        do_reset();
        #1;
        check("R1 rerun", {1'b0, state_o, flags(), ref_credit},
              {1'b0, 3'd0, 5'b00000, 1'b0});

        // R6 SR entry during a read burst
        step(1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_REF, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 rd_busy", {2'b0, state_o, flags()}, {2'b0, 3'd4, 5'b00100});

        // R6 SR entry during a write burst
        do_reset();
        step(1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_REF, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 wr_busy", {2'b0, state_o, flags()}, {2'b0, 3'd4, 5'b00100});

        // R9 hold window measured from SR exit: fall at k=2
        do_reset();
        step(1'b0, C_REF, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 exit", {2'b0, state_o, flags()}, {2'b0, 3'd5, 5'b00000});
        step(1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 after exit", {2'b0, state_o, flags()}, {2'b0, 3'd3, 5'b10000});

        // R8 illegal command on power-down entry
        do_reset();
        step(1'b0, C_ACT, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 entry", {2'b0, state_o, flags()}, {2'b0, 3'd2, 5'b01000});
        step(1'b0, C_NOP, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, C_NOP, 1'b1, 1'b0, 1'b0, 1'b0);
        // R12 clear and new violation at the same edge: set wins
        step(1'b1, C_ACT, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R12 set wins", {2'b0, state_o, flags()}, {2'b0, 3'd1, 5'b01000});
        step(1'b1, C_NOP, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R12 cleared", {2'b0, state_o, flags()}, {2'b0, 3'd1, 5'b00000});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule